// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block holds the speculative architectural-to-physical register mapping of an out-of-order core. Integer, floating-point and condition-code registers each have their own mapping table. A fourth class, the misc registers, is identity-mapped onto a fixed range of physical tags and is never remapped. A rename request names a class and an architectural index. The block reads the current mapping and takes a fresh tag from that class's free-list pop port. It writes the fresh tag into the table and, one cycle later, reports both the new tag and the displaced tag, so that the commit stage can later return the displaced tag to the free list.

The integer and floating-point classes each have a hardwired zero register. A rename of the zero register takes nothing from the free list and reports the same tag as both new and old. The condition-code class has no zero register; its zero index parameter holds an out-of-range value that never matches. A combinational lookup port serves source-operand reads. A set-entry port overwrites one mapping and is used for squash recovery. For the misc class, the set-entry port accepts only the tag the register already holds.

Top module: `rename_map_top`

## Requirements
- R1: After reset, entry i of each renamed class maps to physical tag i, except the zero-register entries: integer index 0 holds tag 63 and floating-point index 31 holds tag 127 (default parameters).
- R2: Class code 0 is integer, 1 is floating point, 2 is condition code and 3 is misc. A rename accepted for a renamed class at a non-zero index pops exactly that class's free list (`fl_pop` bit equal to the class code). It writes the popped tag into the entry and reports that tag as new and the prior mapping as old.
- R3: A rename of the integer or floating-point zero register pops nothing, leaves the table unchanged and reports new equal to old equal to the zero tag. It is accepted even when the free list is empty.
- R4: The condition-code class has no zero register. Every in-range condition-code index, index 0 included, allocates from the free list.
- R5: A misc rename pops nothing and reports new = old = 100 + index. A misc lookup returns the same fixed tag.
- R6: Class codes 4 to 7, and indices at or above the class size (32 integer, 32 floating point, 8 condition code, 8 misc), are errors. Such a rename is accepted with `rsp_err` = 1 and both tags 0, with no pop and no table change. Such a lookup returns `lk_err` = 1 and tag 0.
- R7: The lookup port is combinational, returns the registered mapping and changes no state.
- R8: A set-entry write to a renamed class replaces the mapping, and the new value is visible on lookup in the following cycle.
- R9: A set-entry write to a misc register whose tag differs from 100 + index, or one that carries an invalid class or index, raises `se_err` in the same cycle and changes nothing. A matching misc write raises no error.
- R10: When a rename needs allocation and its class's free list is empty, `rn_ready` is low, nothing is popped and the table is unchanged. The request proceeds once a tag is available.
- R11: When a set-entry write and a rename target the same class and index in the same cycle, the set-entry write is applied and `rn_ready` is low. The rename, held by the requester, then reports the written tag as its old tag.
- R12: Each accepted rename (`rn_valid` and `rn_ready` high at a clock edge) produces exactly one `rsp_valid` pulse in the next cycle. There is no response otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request present |
| rn_class | input | 3 | Rename register class code |
| rn_idx | input | IDX_W | Rename architectural index |
| rn_ready | output | 1 | Rename can be accepted this cycle |
| rsp_valid | output | 1 | Rename result valid |
| rsp_err | output | 1 | Rename named an invalid class or index |
| rsp_new_tag | output | TAG_W | Tag now mapped |
| rsp_old_tag | output | TAG_W | Tag previously mapped |
| fl_avail | input | 3 | Per-class free list has a tag (bit = class code) |
| fl_tag | input | 3*TAG_W | Per-class head tag, class c at bits [c*TAG_W +: TAG_W] |
| fl_pop | output | 3 | Per-class pop strobe |
| lk_class | input | 3 | Lookup class code |
| lk_idx | input | IDX_W | Lookup architectural index |
| lk_tag | output | TAG_W | Current mapping |
| lk_err | output | 1 | Lookup named an invalid class or index |
| se_valid | input | 1 | Set-entry write present |
| se_class | input | 3 | Set-entry class code |
| se_idx | input | IDX_W | Set-entry architectural index |
| se_tag | input | TAG_W | Tag to write |
| se_err | output | 1 | Set-entry write rejected |

## Verification
The hardest case to reach is a set-entry write and a rename that hit the same entry in the same edge. The stimulus has to hold both ports on the same class and index for one cycle, observe the stall, and then release only the set-entry port, so that the rename's reported old tag shows which write won. The empty-free-list stall needs a similar setup. The bench withdraws availability while a rename is held, confirms that no response appears and that the entry is unchanged, and then restores one tag. The bench also renames the zero register while the list is empty, to show that zero-register renames never wait.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int CLS_W      = 3;
    localparam int NUM_MAPPED = 3;

    typedef enum logic [CLS_W-1:0] {
        RC_INT  = 3'd0,
        RC_FP   = 3'd1,
        RC_CC   = 3'd2,
        RC_MISC = 3'd3
    } rclass_e;

endpackage

// File: rtl/rename_class_decode.sv
module rename_class_decode
    import rename_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int INT_N  = 32,
    parameter int FP_N   = 32,
    parameter int CC_N   = 8,
    parameter int MISC_N = 8
) (
    input  logic [CLS_W-1:0] cls,
    input  logic [IDX_W-1:0] idx,
    output logic [3:0]       sel,
    output logic             ok
);

    logic [31:0] idx_w;

    always_comb begin
        idx_w = 32'(idx);
        sel   = 4'b0000;
        ok    = 1'b0;
        case (cls)
            RC_INT: begin
                sel[0] = 1'b1;
                ok     = idx_w < 32'(INT_N);
            end
            RC_FP: begin
                sel[1] = 1'b1;
                ok     = idx_w < 32'(FP_N);
            end
            RC_CC: begin
                sel[2] = 1'b1;
                ok     = idx_w < 32'(CC_N);
            end
            RC_MISC: begin
                sel[3] = 1'b1;
                ok     = idx_w < 32'(MISC_N);
            end
            default: begin
                sel = 4'b0000;
                ok  = 1'b0;
            end
        endcase
        if (!ok) begin
            sel = 4'b0000;
        end
    end

endmodule

// File: rtl/rename_class_table.sv
module rename_class_table #(
    parameter int ENTRIES  = 32,
    parameter int LW       = 5,
    parameter int TAG_W    = 7,
    parameter int ZERO_IDX = 0,
    parameter int ZERO_TAG = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    rd_a_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    input  logic [LW-1:0]    rd_b_idx,
    output logic [TAG_W-1:0] rd_b_tag,
    input  logic             ren_en,
    input  logic [LW-1:0]    ren_idx,
    input  logic [TAG_W-1:0] ren_tag,
    input  logic             set_en,
    input  logic [LW-1:0]    set_idx,
    input  logic [TAG_W-1:0] set_tag
);

    logic [TAG_W-1:0] map_q [ENTRIES];
    logic [TAG_W-1:0] map_d [ENTRIES];

    // Rename write first, squash-restore write last so it wins on a shared entry.
    always_comb begin
        map_d = map_q;
        if (ren_en) begin
            map_d[ren_idx] = ren_tag;
        end
        if (set_en) begin
            map_d[set_idx] = set_tag;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam logic [TAG_W-1:0] RST_TAG =
            (e == ZERO_IDX) ? TAG_W'(ZERO_TAG) : TAG_W'(e);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[e] <= RST_TAG;
            end else begin
                map_q[e] <= map_d[e];
            end
        end
    end

    assign rd_a_tag = map_q[rd_a_idx];
    assign rd_b_tag = map_q[rd_b_idx];

    AST_ZERO_NEVER_REMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ren_en |-> (32'(ren_idx) != 32'(ZERO_IDX))); // R3
    AST_SET_RENAME_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && ren_en && (set_idx == ren_idx))); // R11
    AST_IDLE_TABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !ren_en) ##1 $stable(rd_b_idx) |-> $stable(rd_b_tag)); // R7

endmodule

// File: rtl/rename_map_top.sv
module rename_map_top
    import rename_pkg::*;
#(
    parameter int IDX_W         = 5,
    parameter int TAG_W         = 7,
    parameter int INT_N         = 32,
    parameter int FP_N          = 32,
    parameter int CC_N          = 8,
    parameter int MISC_N        = 8,
    parameter int INT_ZERO_IDX  = 0,
    parameter int INT_ZERO_TAG  = 63,
    parameter int FP_ZERO_IDX   = 31,
    parameter int FP_ZERO_TAG   = 127,
    parameter int CC_ZERO_IDX   = 31,
    parameter int MISC_TAG_BASE = 100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rn_valid,
    input  logic [CLS_W-1:0]            rn_class,
    input  logic [IDX_W-1:0]            rn_idx,
    output logic                        rn_ready,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [TAG_W-1:0]            rsp_new_tag,
    output logic [TAG_W-1:0]            rsp_old_tag,
    input  logic [NUM_MAPPED-1:0]       fl_avail,
    input  logic [NUM_MAPPED*TAG_W-1:0] fl_tag,
    output logic [NUM_MAPPED-1:0]       fl_pop,
    input  logic [CLS_W-1:0]            lk_class,
    input  logic [IDX_W-1:0]            lk_idx,
    output logic [TAG_W-1:0]            lk_tag,
    output logic                        lk_err,
    input  logic                        se_valid,
    input  logic [CLS_W-1:0]            se_class,
    input  logic [IDX_W-1:0]            se_idx,
    input  logic [TAG_W-1:0]            se_tag,
    output logic                        se_err
);

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [TAG_W-1:0] new_tag;
        logic [TAG_W-1:0] old_tag;
    } rsp_t;

    function automatic logic [TAG_W-1:0] misc_tag(input logic [IDX_W-1:0] i);
        return TAG_W'(32'(MISC_TAG_BASE) + 32'(i));
    endfunction

    // ---------------------------------------------------------------- decode
    logic [3:0] rn_sel, lk_sel, se_sel;
    logic       rn_ok, lk_ok, se_ok;

    rename_class_decode #(
        .IDX_W(IDX_W), .INT_N(INT_N), .FP_N(FP_N), .CC_N(CC_N), .MISC_N(MISC_N)
    ) u_rn_dec (.cls(rn_class), .idx(rn_idx), .sel(rn_sel), .ok(rn_ok));

    rename_class_decode #(
        .IDX_W(IDX_W), .INT_N(INT_N), .FP_N(FP_N), .CC_N(CC_N), .MISC_N(MISC_N)
    ) u_lk_dec (.cls(lk_class), .idx(lk_idx), .sel(lk_sel), .ok(lk_ok));

    rename_class_decode #(
        .IDX_W(IDX_W), .INT_N(INT_N), .FP_N(FP_N), .CC_N(CC_N), .MISC_N(MISC_N)
    ) u_se_dec (.cls(se_class), .idx(se_idx), .sel(se_sel), .ok(se_ok));

    // ---------------------------------------------------------------- tables
    logic [TAG_W-1:0]      rn_cur   [NUM_MAPPED];
    logic [TAG_W-1:0]      lk_cur   [NUM_MAPPED];
    logic [TAG_W-1:0]      head_tag [NUM_MAPPED];
    logic [NUM_MAPPED-1:0] set_en;

    for (genvar g = 0; g < NUM_MAPPED; g++) begin : g_cls
        localparam int N  = (g == 0) ? INT_N : (g == 1) ? FP_N : CC_N;
        localparam int ZI = (g == 0) ? INT_ZERO_IDX : (g == 1) ? FP_ZERO_IDX : CC_ZERO_IDX;
        localparam int ZT = (g == 0) ? INT_ZERO_TAG : (g == 1) ? FP_ZERO_TAG : 0;
        localparam int LW = (N > 1) ? $clog2(N) : 1;

        assign head_tag[g] = fl_tag[g*TAG_W +: TAG_W];
        assign set_en[g]   = se_valid && se_sel[g];

        rename_class_table #(
            .ENTRIES(N), .LW(LW), .TAG_W(TAG_W), .ZERO_IDX(ZI), .ZERO_TAG(ZT)
        ) u_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_a_idx (rn_idx[LW-1:0]),
            .rd_a_tag (rn_cur[g]),
            .rd_b_idx (lk_idx[LW-1:0]),
            .rd_b_tag (lk_cur[g]),
            .ren_en   (fl_pop[g]),
            .ren_idx  (rn_idx[LW-1:0]),
            .ren_tag  (head_tag[g]),
            .set_en   (set_en[g]),
            .set_idx  (se_idx[LW-1:0]),
            .set_tag  (se_tag)
        );
    end

    // ---------------------------------------------------------------- rename path
    rsp_t             rsp_d, rsp_q;
    logic             rn_zero, rn_alloc, rn_avail, rn_collide, rn_fire;
    logic [TAG_W-1:0] rn_old, rn_head;

    always_comb begin
        rn_zero = (rn_sel[0] && (32'(rn_idx) == 32'(INT_ZERO_IDX)))
               || (rn_sel[1] && (32'(rn_idx) == 32'(FP_ZERO_IDX)))
               || (rn_sel[2] && (32'(rn_idx) == 32'(CC_ZERO_IDX)));
        rn_alloc   = rn_ok && !rn_sel[3] && !rn_zero;
        rn_avail   = |(rn_sel[NUM_MAPPED-1:0] & fl_avail);
        rn_collide = se_valid && se_ok && !se_sel[3]
                  && (se_class == rn_class) && (se_idx == rn_idx);
        rn_ready   = !rn_collide && !(rn_alloc && !rn_avail);
        rn_fire    = rn_valid && rn_ready;
        fl_pop     = (rn_fire && rn_alloc) ? rn_sel[NUM_MAPPED-1:0] : '0;

        rn_old  = '0;
        rn_head = '0;
        for (int c = 0; c < NUM_MAPPED; c++) begin
            if (rn_sel[c]) begin
                rn_old  = rn_cur[c];
                rn_head = head_tag[c];
            end
        end
        if (rn_sel[3]) begin
            rn_old = misc_tag(rn_idx);
        end

        rsp_d.valid   = rn_fire;
        rsp_d.err     = !rn_ok;
        rsp_d.old_tag = rn_old;
        rsp_d.new_tag = rn_alloc ? rn_head : rn_old;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_err     = rsp_q.err;
    assign rsp_new_tag = rsp_q.new_tag;
    assign rsp_old_tag = rsp_q.old_tag;

    // ---------------------------------------------------------------- lookup and set-entry
    always_comb begin
        lk_tag = '0;
        for (int c = 0; c < NUM_MAPPED; c++) begin
            if (lk_sel[c]) begin
                lk_tag = lk_cur[c];
            end
        end
        if (lk_sel[3]) begin
            lk_tag = misc_tag(lk_idx);
        end
        lk_err = !lk_ok;
        se_err = se_valid && (!se_ok || (se_sel[3] && (se_tag != misc_tag(se_idx))));
    end

    AST_POP_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_pop & ~fl_avail) == '0); // R10
    AST_POP_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_pop)); // R2
    AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !rn_ready |-> (fl_pop == '0)); // R10
    AST_RSP_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && rn_ready) |=> rsp_valid); // R12
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rn_valid && rn_ready) |=> !rsp_valid); // R12
    AST_NOPOP_SAME_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && rn_ready && (fl_pop == '0)) |=> (rsp_new_tag == rsp_old_tag)); // R3

endmodule

// File: tb/rename_map_top_tb_top.sv
`timescale 1ns/1ps
module rename_map_top_tb_top;

    localparam int IDX_W = 5;
    localparam int TAG_W = 7;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 rn_valid;
    logic [2:0]           rn_class;
    logic [IDX_W-1:0]     rn_idx;
    logic                 rn_ready;
    logic                 rsp_valid, rsp_err;
    logic [TAG_W-1:0]     rsp_new_tag, rsp_old_tag;
    logic [2:0]           fl_avail;
    logic [3*TAG_W-1:0]   fl_tag;
    logic [2:0]           fl_pop;
    logic [2:0]           lk_class;
    logic [IDX_W-1:0]     lk_idx;
    logic [TAG_W-1:0]     lk_tag;
    logic                 lk_err;
    logic                 se_valid;
    logic [2:0]           se_class;
    logic [IDX_W-1:0]     se_idx;
    logic [TAG_W-1:0]     se_tag;
    logic                 se_err;

    always #4 clk = ~clk;

    rename_map_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .rn_valid(rn_valid), .rn_class(rn_class), .rn_idx(rn_idx), .rn_ready(rn_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_new_tag(rsp_new_tag), .rsp_old_tag(rsp_old_tag),
        .fl_avail(fl_avail), .fl_tag(fl_tag), .fl_pop(fl_pop),
        .lk_class(lk_class), .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_err(lk_err),
        .se_valid(se_valid), .se_class(se_class), .se_idx(se_idx), .se_tag(se_tag),
        .se_err(se_err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [2*TAG_W:0] exp_q [$];
    string            req_q [$];
    logic [TAG_W-1:0] mdl [3][32];

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check_eq("R12", "unexpected response", 1, 0);
            end else begin
                logic [2*TAG_W:0] e;
                string            r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check_eq(r, "rsp_err", int'(rsp_err), int'(e[2*TAG_W]));
                check_eq(r, "rsp_new_tag", int'(rsp_new_tag), int'(e[2*TAG_W-1:TAG_W]));
                check_eq(r, "rsp_old_tag", int'(rsp_old_tag), int'(e[TAG_W-1:0]));
            end
        end
    end

    function automatic bit idx_ok(input logic [2:0] c, input logic [IDX_W-1:0] i);
        case (c)
            3'd0, 3'd1: return 1'b1;
            3'd2, 3'd3: return i < 8;
            default:    return 1'b0;
        endcase
    endfunction

    task automatic do_rename(input logic [2:0] c, input logic [IDX_W-1:0] i,
                             input logic [TAG_W-1:0] ft, input string req);
        logic [2*TAG_W:0] e;
        logic [2:0]       pop_exp;
        @(negedge clk);
        rn_valid = 1; rn_class = c; rn_idx = i;
        fl_avail = 3'b111; fl_tag = {3{ft}};
        pop_exp = 3'b000;
        if (!idx_ok(c, i)) begin
            e = {1'b1, 7'd0, 7'd0};
        end else if (c == 3'd3) begin
            e = {1'b0, 7'(100 + i), 7'(100 + i)};
        end else if ((c == 3'd0 && i == 0) || (c == 3'd1 && i == 31)) begin
            e = {1'b0, mdl[c][i], mdl[c][i]};
        end else begin
            e = {1'b0, ft, mdl[c][i]};
            pop_exp = 3'b001 << c;
            mdl[c][i] = ft;
        end
        #1;
        check_eq(req, "rn_ready", int'(rn_ready), 1);
        check_eq(req, "fl_pop", int'(fl_pop), int'(pop_exp));
        exp_q.push_back(e);
        req_q.push_back(req);
        @(posedge clk);
        #1 rn_valid = 0;
    endtask

    task automatic chk_lk(input logic [2:0] c, input logic [IDX_W-1:0] i,
                          input int exp_tag, input int exp_err, input string req);
        lk_class = c; lk_idx = i;
        #1;
        check_eq(req, "lk_tag", int'(lk_tag), exp_tag);
        check_eq(req, "lk_err", int'(lk_err), exp_err);
    endtask

    task automatic do_set(input logic [2:0] c, input logic [IDX_W-1:0] i,
                          input logic [TAG_W-1:0] t, input int exp_err, input string req);
        @(negedge clk);
        se_valid = 1; se_class = c; se_idx = i; se_tag = t;
        #1;
        check_eq(req, "se_err", int'(se_err), exp_err);
        @(posedge clk);
        #1 se_valid = 0;
        if (exp_err == 0 && c < 3) mdl[c][i] = t;
    endtask

    initial begin
        #(200000 * 8);
        check_eq("watchdog", "timeout", 1, 0);
        finish_sim();
    end

    initial begin
        rst_n = 0; rn_valid = 0; rn_class = 0; rn_idx = 0;
        fl_avail = 0; fl_tag = 0; lk_class = 0; lk_idx = 0;
        se_valid = 0; se_class = 0; se_idx = 0; se_tag = 0;
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < 32; i++) mdl[c][i] = 7'(i);
        end
        mdl[0][0]  = 7'd63;
        mdl[1][31] = 7'd127;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        check_eq("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        chk_lk(3'd0, 5'd0, 63, 0, "R1");
        chk_lk(3'd0, 5'd7, 7, 0, "R1");
        chk_lk(3'd1, 5'd31, 127, 0, "R1");
        chk_lk(3'd1, 5'd4, 4, 0, "R1");
        chk_lk(3'd2, 5'd3, 3, 0, "R1");

        // R2 plain renames
        do_rename(3'd0, 5'd5, 7'd40, "R2");
        do_rename(3'd0, 5'd5, 7'd41, "R2");
        do_rename(3'd1, 5'd10, 7'd90, "R2");
        chk_lk(3'd0, 5'd5, 41, 0, "R2");
        chk_lk(3'd1, 5'd10, 90, 0, "R2");

        // R3 zero registers
        do_rename(3'd0, 5'd0, 7'd50, "R3");
        do_rename(3'd1, 5'd31, 7'd51, "R3");
        chk_lk(3'd0, 5'd0, 63, 0, "R3");
        chk_lk(3'd1, 5'd31, 127, 0, "R3");

        // R4 condition codes allocate at every index
        do_rename(3'd2, 5'd0, 7'd20, "R4");
        do_rename(3'd2, 5'd7, 7'd21, "R4");
        chk_lk(3'd2, 5'd0, 20, 0, "R4");

        // R5 misc fixed
        do_rename(3'd3, 5'd2, 7'd55, "R5");
        chk_lk(3'd3, 5'd5, 105, 0, "R5");

        // R6 errors
        do_rename(3'd5, 5'd1, 7'd56, "R6");
        do_rename(3'd2, 5'd9, 7'd57, "R6");
        chk_lk(3'd6, 5'd1, 0, 1, "R6");
        chk_lk(3'd2, 5'd12, 0, 1, "R6");
        chk_lk(3'd0, 5'd1, 1, 0, "R6");

        // R7 lookup leaves state alone
        chk_lk(3'd0, 5'd5, 41, 0, "R7");
        @(posedge clk);
        chk_lk(3'd0, 5'd5, 41, 0, "R7");

        // R8 set-entry
        do_set(3'd0, 5'd9, 7'd70, 0, "R8");
        chk_lk(3'd0, 5'd9, 70, 0, "R8");
        do_set(3'd1, 5'd3, 7'd71, 0, "R8");
        chk_lk(3'd1, 5'd3, 71, 0, "R8");

        // R9 misc set-entry and invalid set-entry
        do_set(3'd3, 5'd4, 7'd104, 0, "R9");
        do_set(3'd3, 5'd4, 7'd50, 1, "R9");
        chk_lk(3'd3, 5'd4, 104, 0, "R9");
        do_set(3'd7, 5'd2, 7'd33, 1, "R9");
        chk_lk(3'd2, 5'd2, 2, 0, "R9");

        // R10 stall on empty free list
        @(negedge clk);
        rn_valid = 1; rn_class = 3'd0; rn_idx = 5'd12; fl_avail = 3'b000; fl_tag = {3{7'd45}};
        #1;
        check_eq("R10", "rn_ready empty", int'(rn_ready), 0);
        check_eq("R10", "fl_pop empty", int'(fl_pop), 0);
        @(negedge clk);
        chk_lk(3'd0, 5'd12, 12, 0, "R10");
        // zero register needs no tag (R3)
        rn_idx = 5'd0;
        #1 check_eq("R3", "rn_ready zero reg empty list", int'(rn_ready), 1);
        rn_idx = 5'd12;
        #1;
        @(negedge clk);
        fl_avail = 3'b001;
        #1;
        check_eq("R10", "rn_ready restored", int'(rn_ready), 1);
        check_eq("R10", "fl_pop restored", int'(fl_pop), 1);
        exp_q.push_back({1'b0, 7'd45, 7'd12});
        req_q.push_back("R10");
        mdl[0][12] = 7'd45;
        @(posedge clk);
        #1 rn_valid = 0;
        chk_lk(3'd0, 5'd12, 45, 0, "R10");

        // R11 set-entry wins over rename on the same entry
        @(negedge clk);
        rn_valid = 1; rn_class = 3'd0; rn_idx = 5'd6; fl_avail = 3'b111; fl_tag = {3{7'd46}};
        se_valid = 1; se_class = 3'd0; se_idx = 5'd6; se_tag = 7'd77;
        #1;
        check_eq("R11", "rn_ready collide", int'(rn_ready), 0);
        check_eq("R11", "fl_pop collide", int'(fl_pop), 0);
        @(posedge clk);
        #1 se_valid = 0;
        @(negedge clk);
        #1;
        check_eq("R11", "rn_ready after set", int'(rn_ready), 1);
        exp_q.push_back({1'b0, 7'd46, 7'd77});
        req_q.push_back("R11");
        @(posedge clk);
        #1 rn_valid = 0;
        chk_lk(3'd0, 5'd6, 46, 0, "R11");

        repeat (3) @(posedge clk);
        check_eq("R12", "pending responses", exp_q.size(), 0);
        finish_sim();
    end

endmodule